// File: doc/BRIEF.md
# Three-Operand Integer Adder with Condition Flags

This block is one slice of an integer execution pipeline. It takes a 64-bit instruction word and three operands that have already been read, and in a single operation forms A + B + C. Any operand may be negated as two's complement. In register form, any operand may first be cut down to its low or high 16-bit half, zero-extended. The partial sum A + B can be moved 16 bits left or right before C is added. A right move acts on the 33-bit sum, so it keeps the carry of A + B. As an option, the stored carry flag can be added into the partial sum.

The result and the destination register index are registered on the input strobe and come out one cycle later with an output strobe. When the instruction requests it, four held flags are updated: zero, sign, carry and overflow. The held carry flag also feeds the extended-add path of later operations. Some control combinations have no defined meaning. For these the block raises an illegal flag and changes neither the write nor the flags.

Top module: `add3_flags`

## Requirements
- R1: Instruction bits [7:0] give the destination index, copied to `out_dest` on a legal operation. Bit 51 negates A, bit 50 negates B and bit 49 negates C. Each negation is two's complement and is applied before any addition.
- R2: In register form (`in_reg_form`=1), the half selects are A = bits [36:35], B = bits [34:33] and C = bits [32:31]. The codes are 0 whole word, 1 bits [15:0] zero-extended, 2 bits [31:16] zero-extended. The half select is applied before negation.
- R3: Shift select bits [38:37] set to 2 move the partial sum A+B left by 16 before C is added.
- R4: Shift select 1 moves the partial sum logically right by 16. It then adds 0x10000 when A+B carried out of bit 31.
- R5: Bit 48 (extended) adds the held carry flag (as 0 or 1) into the partial sum A+B.
- R6: When bit 47 is set on a legal operation, the flags are updated. Z is set when the result is zero, S takes result bit 31, and C takes the carry out of the final addition. When bit 47 is clear, all four flags keep their values.
- R7: The overflow flag is the signed overflow of the final addition, ORed with (partial sum < negated-or-plain A, unsigned).
- R8: With `in_reg_form`=0, bits [38:31] are ignored: there is no half select and no shift, and code 3 in those bits is not illegal.
- R9: An operation is illegal in these cases: extended is set together with a right shift; extended is set together with bit 47; or, in register form, any shift or half field holds code 3. An illegal operation gives `out_illegal`=1 and `out_wr`=0, and leaves the flags, `out_result` and `out_dest` unchanged.
- R10: `out_valid` pulses exactly one cycle after each `in_valid` cycle, and only then. `out_wr` and `out_illegal` are 0 when `out_valid` is 0.
- R11: After reset, all outputs and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_insn | input | 64 | Instruction word |
| in_reg_form | input | 1 | 1: register form (half and shift fields in use) |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_c | input | 32 | Operand C |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_wr | output | 1 | Legal result, register write enable |
| out_illegal | output | 1 | Operation rejected |
| out_dest | output | 8 | Destination register index |
| out_result | output | 32 | Sum |
| flag_z | output | 1 | Held zero flag |
| flag_s | output | 1 | Held sign flag |
| flag_c | output | 1 | Held carry flag |
| flag_o | output | 1 | Held overflow flag |

## Verification
The hardest case to reach from the ports is the 33-bit correction on a right shift. It needs A and B, after half selection and negation, to carry out while their 32-bit sum still leaves a visible high half. The stimulus uses 0xFFFF0000 + 0x00020000 so that the added 0x10000 appears directly in the result. A second hard case is the second overflow term, which needs a partial sum that wraps below A while C causes no signed overflow. A third is the extended carry, which must first be loaded by a flag-writing operation whose final addition carries, and is then used by a following operation.

// File: rtl/add3_flags.sv
module add3_flags #(
  parameter int W  = 32,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [63:0]   in_insn,
  input  logic          in_reg_form,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [W-1:0]  in_c,
  output logic          out_valid,
  output logic          out_wr,
  output logic          out_illegal,
  output logic [RW-1:0] out_dest,
  output logic [W-1:0]  out_result,
  output logic          flag_z,
  output logic          flag_s,
  output logic          flag_c,
  output logic          flag_o
);
  localparam int HW = W / 2;
  localparam logic [W-1:0] HI_ONE = W'(1) << HW;

  function automatic logic [W-1:0] pick(input logic [W-1:0] v, input logic [1:0] sel);
    case (sel)
      2'd1:    pick = {{(W-HW){1'b0}}, v[HW-1:0]};
      2'd2:    pick = {{HW{1'b0}}, v[W-1:HW]};
      default: pick = v;
    endcase
  endfunction

  wire cc_en = in_insn[47];
  wire ext   = in_insn[48];
  wire neg_c = in_insn[49];
  wire neg_b = in_insn[50];
  wire neg_a = in_insn[51];

  wire [1:0] shf = in_reg_form ? in_insn[38:37] : 2'd0;
  wire [1:0] hsa = in_reg_form ? in_insn[36:35] : 2'd0;
  wire [1:0] hsb = in_reg_form ? in_insn[34:33] : 2'd0;
  wire [1:0] hsc = in_reg_form ? in_insn[32:31] : 2'd0;

  wire unused_bits = ^{in_insn[63:52], in_insn[46:39], in_insn[30:8]};

  wire bad_code = (shf == 2'd3) || (hsa == 2'd3) || (hsb == 2'd3) || (hsc == 2'd3);
  wire illegal  = bad_code || (ext && shf == 2'd1) || (ext && cc_en);

  wire [W-1:0] pa = pick(in_a, hsa);
  wire [W-1:0] pb = pick(in_b, hsb);
  wire [W-1:0] pc = pick(in_c, hsc);
  wire [W-1:0] na = neg_a ? -pa : pa;
  wire [W-1:0] nb = neg_b ? -pb : pb;
  wire [W-1:0] nc = neg_c ? -pc : pc;

  wire [W:0]   sum_ab = {1'b0, na} + {1'b0, nb};
  wire [W-1:0] lhs1   = sum_ab[W-1:0] + {{(W-1){1'b0}}, ext & flag_c};

  logic [W-1:0] shifted;
  always_comb begin
    case (shf)
      2'd1:    shifted = (lhs1 >> HW) + (sum_ab[W] ? HI_ONE : '0);
      2'd2:    shifted = lhs1 << HW;
      default: shifted = lhs1;
    endcase
  end

  wire [W:0]   fin = {1'b0, shifted} + {1'b0, nc};
  wire [W-1:0] res = fin[W-1:0];
  wire sovf = (shifted[W-1] == nc[W-1]) && (res[W-1] != shifted[W-1]);
  wire pwrap = lhs1 < na;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_wr      <= 1'b0;
      out_illegal <= 1'b0;
      out_dest    <= '0;
      out_result  <= '0;
      flag_z      <= 1'b0;
      flag_s      <= 1'b0;
      flag_c      <= 1'b0;
      flag_o      <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_wr      <= in_valid && !illegal;
      out_illegal <= in_valid && illegal;
      if (in_valid && !illegal) begin
        out_dest   <= in_insn[RW-1:0];
        out_result <= res;
        if (cc_en) begin
          flag_z <= (res == '0);
          flag_s <= res[W-1];
          flag_c <= fin[W];
          flag_o <= sovf | pwrap;
        end
      end
    end
  end
endmodule

// File: rtl/add3_flags_chk.sv
module add3_flags_chk #(
  parameter int W  = 32,
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic          out_wr,
  input logic          out_illegal,
  input logic [RW-1:0] out_dest,
  input logic [W-1:0]  out_result,
  input logic          flag_z,
  input logic          flag_s,
  input logic          flag_c,
  input logic          flag_o
);
  wire [3:0] flags = {flag_z, flag_s, flag_c, flag_o};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R10
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> !out_wr && !out_illegal); // R10
  AST_WR_XOR_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $onehot({out_wr, out_illegal})); // R9
  AST_ILLEGAL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n) out_illegal |-> $stable(flags) && $stable(out_result) && $stable(out_dest)); // R9
  AST_FLAGS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(flags) |-> out_wr); // R6
  AST_ZERO_MATCHES: assert property (@(posedge clk) disable iff (!rst_n) !$stable(flags) |-> flag_z == (out_result == '0)); // R6
  AST_SIGN_MATCHES: assert property (@(posedge clk) disable iff (!rst_n) !$stable(flags) |-> flag_s == out_result[W-1]); // R6
endmodule

bind add3_flags add3_flags_chk #(.W(W), .RW(RW)) chk_i (.*);

// File: tb/add3_flags_tb_top.sv
module add3_flags_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_insn = '0;
  logic        in_reg_form = 1'b0;
  logic [31:0] in_a = '0, in_b = '0, in_c = '0;
  logic        out_valid, out_wr, out_illegal;
  logic [7:0]  out_dest;
  logic [31:0] out_result;
  logic        flag_z, flag_s, flag_c, flag_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_res = '0;
  logic [7:0]  m_dest = '0;
  logic [3:0]  m_fl = '0;

  always #5 clk = ~clk;

  add3_flags dut_i (.*);

  function automatic logic [63:0] mk(input int dest, input bit cc, input bit x,
      input bit ngc, input bit ngb, input bit nga,
      input int sh, input int ha, input int hb, input int hc);
    logic [63:0] w = '0;
    w[7:0] = 8'(dest); w[47] = cc; w[48] = x;
    w[49] = ngc; w[50] = ngb; w[51] = nga;
    w[38:37] = 2'(sh); w[36:35] = 2'(ha); w[34:33] = 2'(hb); w[32:31] = 2'(hc);
    return w;
  endfunction

  function automatic longint unsigned half_of(input longint unsigned v, input int s);
    if (s == 1) return v % 65536;
    if (s == 2) return v / 65536;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] w, input bit rf, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] c, input string req);
    longint unsigned M = 64'h1_0000_0000;
    int sh = rf ? int'(w[38:37]) : 0;
    int ha = rf ? int'(w[36:35]) : 0;
    int hb = rf ? int'(w[34:33]) : 0;
    int hc = rf ? int'(w[32:31]) : 0;
    bit x = w[48], cc = w[47];
    bit bad = (sh == 3) || (ha == 3) || (hb == 3) || (hc == 3) || (x && sh == 1) || (x && cc);
    longint unsigned va, vb, vc, s1, l1, sv, f;
    longint sa, sc, ssum;
    bit cab, ov;
    va = half_of(a, ha); vb = half_of(b, hb); vc = half_of(c, hc);
    if (w[51]) va = (M - va) % M;
    if (w[50]) vb = (M - vb) % M;
    if (w[49]) vc = (M - vc) % M;
    s1 = va + vb;
    cab = s1 >= M;
    l1 = (s1 + (x ? longint'(m_fl[1]) : 0)) % M;
    if (sh == 2) sv = (l1 * 65536) % M;
    else if (sh == 1) sv = l1 / 65536 + (cab ? 65536 : 0);
    else sv = l1;
    f = sv + vc;
    sa = (sv >= M/2) ? longint'(sv) - longint'(M) : longint'(sv);
    sc = (vc >= M/2) ? longint'(vc) - longint'(M) : longint'(vc);
    ssum = sa + sc;
    ov = (ssum > 64'sd2147483647) || (ssum < -64'sd2147483648) || (l1 < va);
    if (!bad) begin
      m_res = 32'(f % M);
      m_dest = w[7:0];
      if (cc) m_fl = {(f % M) == 0, (f % M) >= M/2, f >= M, ov};
    end
    @(negedge clk);
    in_insn = w; in_reg_form = rf; in_a = a; in_b = b; in_c = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid, req, "out_valid", out_valid, 1);
    chk(out_illegal == bad && out_wr == !bad, req, "illegal/wr", {out_illegal, out_wr}, {bad, !bad});
    chk(out_result == m_res, req, "result", out_result, m_res);
    chk(out_dest == m_dest, req, "dest", out_dest, m_dest);
    chk({flag_z, flag_s, flag_c, flag_o} == m_fl, req, "flags ZSCO",
        {flag_z, flag_s, flag_c, flag_o}, m_fl);
  endtask

  task automatic t_reset;
    chk({out_valid, out_wr, out_illegal} == 0 && out_result == 0 && out_dest == 0 &&
        {flag_z, flag_s, flag_c, flag_o} == 0, "R11", "reset state", out_result, 0);
  endtask

  task automatic t_basic_negate;
    run_op(mk(3, 0, 0, 0, 0, 0, 0, 0, 0, 0), 1, 5, 7, 10, "R1");
    run_op(mk(9, 1, 0, 0, 1, 0, 0, 0, 0, 0), 1, 100, 30, 5, "R1");
    run_op(mk(12, 1, 0, 1, 0, 1, 0, 0, 0, 0), 0, 40, 50, 10, "R1");
  endtask

  task automatic t_halves;
    run_op(mk(4, 0, 0, 0, 0, 0, 0, 2, 1, 0), 1, 32'h1234ABCD, 32'hFFFF0001, 32'h00050000, "R2");
    run_op(mk(5, 0, 0, 1, 0, 0, 0, 0, 0, 2), 1, 32'h10, 32'h20, 32'h00030000, "R2");
  endtask

  task automatic t_shifts;
    run_op(mk(6, 0, 0, 0, 0, 0, 2, 0, 0, 0), 1, 1, 2, 32'h55, "R3");
    run_op(mk(7, 0, 0, 0, 0, 0, 1, 0, 0, 0), 1, 32'hFFFF0000, 32'h00020000, 0, "R4");
    run_op(mk(7, 0, 0, 0, 0, 0, 1, 0, 0, 0), 1, 32'h00120000, 32'h00030000, 1, "R4");
  endtask

  task automatic t_flags_carry;
    run_op(mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 1, 32'hFFFFFFFF, 0, 1, "R6");
    run_op(mk(2, 0, 1, 0, 0, 0, 0, 0, 0, 0), 1, 1, 2, 3, "R5");
    run_op(mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0), 1, 8, 8, 8, "R6");
    run_op(mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 1, 32'h7FFFFFFF, 0, 1, "R7");
    run_op(mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 1, 32'hFFFFFFFF, 2, 0, "R7");
    run_op(mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 1, 3, 4, 5, "R6");
  endtask

  task automatic t_nonreg;
    run_op(mk(8, 0, 0, 0, 0, 0, 3, 3, 3, 3), 0, 32'h11110000, 32'h2222, 32'h3, "R8");
    run_op(mk(8, 0, 0, 0, 0, 0, 2, 1, 2, 1), 0, 32'hABCD0000, 32'h1, 32'h10000, "R8");
  endtask

  task automatic t_illegal;
    run_op(mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 1, 32'hFFFFFFFF, 0, 1, "R9");
    run_op(mk(20, 0, 1, 0, 0, 0, 1, 0, 0, 0), 1, 1, 1, 1, "R9");
    run_op(mk(21, 1, 1, 0, 0, 0, 0, 0, 0, 0), 1, 1, 1, 1, "R9");
    run_op(mk(22, 1, 0, 0, 0, 0, 0, 3, 0, 0), 1, 1, 1, 1, "R9");
    run_op(mk(23, 1, 0, 0, 0, 0, 3, 0, 0, 0), 1, 1, 1, 1, "R9");
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk(!out_valid && !out_wr && !out_illegal, "R10", "idle strobes",
        {out_valid, out_wr, out_illegal}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic_negate();
    t_halves();
    t_shifts();
    t_flags_carry();
    t_nonreg();
    t_illegal();
    t_idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule